// File: doc/BRIEF.md
# Device Reset Sequencing Controller

This block sequences the power and reset state of a data converter's digital core. Three things can reset it. The supply monitor's power-on reset clears it asynchronously. An active-low hardware reset pin is synchronised inside the block. The third is a two-step software reset that the serial host issues through decoded register writes. The block reports its progress on a two-bit power state field and an in-reset flag. While the host must keep away, it holds the serial interface's write-enable gate closed.

Every reset passes through a reset phase that lasts a fixed number of clock cycles. After that phase the block settles in STANDBY. During the phase it drives a reset to the register file. A hardware reset or power-on reset also clears the digital filter. If a hardware reset arrives during a conversion, the block raises a one-cycle abort. A software reset restores registers and state machines only, so it leaves the filter alone. The power-down field is held inside this block, because it is one half of the software reset sequence.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, the outputs read `pwr_state`=2'b11, `in_reset`=1, `host_wr_en`=0, `regs_rst`=1, `filt_clr`=1 and `conv_abort`=0. After `por_n` rises, STANDBY is reached on the (RST_CYCLES+2)-th rising edge.
- R2: The power state codes are 2'b11 RESET, 2'b10 STANDBY and 2'b00 ACTIVE (converting). `in_reset` is 1 exactly when `pwr_state` is 2'b11.
- R3: `host_wr_en` is 1 exactly when the block is not in RESET. Power-down writes and conversion commands that arrive during RESET have no effect.
- R4: A low level on `hw_rst_n`, once it has passed the two synchroniser stages, puts the block in RESET on the third rising edge. That reset phase has `regs_rst`=1 and `filt_clr`=1.
- R5: When a hardware reset catches the block in ACTIVE, `conv_abort` is high for exactly one cycle, in the first cycle of RESET.
- R6: When a reset phase ends, the block enters STANDBY (`in_reset`=0, `pwr_state`=2'b10) and stays there until a command arrives.
- R7: A software reset is a power-down write of 2'b11 followed by a conversion command with mode 2'b01. It enters RESET on the edge that takes the command and holds there for RST_CYCLES cycles, with `regs_rst`=1, `filt_clr`=0 and `conv_abort`=0. It then goes to STANDBY.
- R8: A software reset returns the power-down field to 2'b00. A later mode 2'b01 command is therefore an ordinary command.
- R9: A conversion command with mode 2'b01 while the power-down field is not 2'b11 is ordinary: it moves STANDBY to ACTIVE and causes no reset. A power-down write of 2'b01 returns ACTIVE to STANDBY.
- R10: The reset phase counts RST_CYCLES cycles from the last cycle in which a reset request is seen. A hardware request that is still held restarts the count.
- R11: If a hardware request and the completing software command land on the same edge, the hardware reset wins. `filt_clr` is then 1, and the power-down field is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous active-low power-on reset from the supply monitor |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin |
| pd_wr | input | 1 | Decoded write strobe for the power-down field |
| pd_val | input | 2 | Value written to the power-down field |
| cmd_wr | input | 1 | Decoded conversion command strobe |
| cmd_mode | input | 2 | Mode field of the conversion command |
| pwr_state | output | 2 | Power state status code |
| in_reset | output | 1 | Reset-in-progress status flag |
| regs_rst | output | 1 | Reset to the register file |
| filt_clr | output | 1 | Clear of the digital filter state |
| conv_abort | output | 1 | One-cycle abort of a running conversion |
| host_wr_en | output | 1 | Write-enable gate for the serial interface |

## Verification
The hardest case to reach is a hardware request and the completing software command arriving on the same edge. The pin goes through two synchroniser stages, so the two events cannot simply be driven together. The stimulus first arms the power-down field with 2'b11 and then lowers the pin. It waits exactly two edges and only then presents the mode 2'b01 command, so that both requests meet on the third edge. The bench then checks for a hard-kind reset and a cleared field. The blocked-write case is reached in a similar way: the full software sequence is replayed inside a reset phase, and a later command must show ordinary behaviour.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'b00,
    PS_STANDBY = 2'b10,
    PS_RESET   = 2'b11
  } pstate_t;

  localparam logic [1:0] PD_ARM_RESET = 2'b11;
  localparam logic [1:0] PD_GO_IDLE   = 2'b01;
  localparam logic [1:0] MODE_RESET   = 2'b01;
  localparam logic [1:0] PD_DEFAULT   = 2'b00;

  // Second half of the software reset: a reset-mode command while armed
  function automatic logic completes_soft_reset(input logic [1:0] pd_field,
                                                input logic [1:0] mode);
    return (pd_field == PD_ARM_RESET) && (mode == MODE_RESET);
  endfunction

  function automatic logic asks_for_standby(input logic [1:0] pd_value);
    return pd_value == PD_GO_IDLE;
  endfunction

  function automatic logic phase_done(input int unsigned count,
                                      input int unsigned length);
    return count == (length - 1);
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // Clears to 0 so the pin reads as asserted until it has been sampled
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsq_cmd_decode.sv
module rsq_cmd_decode
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rq,
  input  logic       host_wr_en,
  input  logic       pd_wr,
  input  logic [1:0] pd_val,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_mode,
  output logic       soft_trig,
  output logic       ord_cmd,
  output logic       stby_req
);
  logic [1:0] pd_q;
  logic       cmd_ok;
  logic       pd_ok;

  assign cmd_ok    = cmd_wr && host_wr_en && !hw_rq;
  assign pd_ok     = pd_wr  && host_wr_en && !hw_rq;
  assign soft_trig = cmd_ok && completes_soft_reset(pd_q, cmd_mode);
  assign ord_cmd   = cmd_ok && !soft_trig;
  assign stby_req  = pd_ok && asks_for_standby(pd_val);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                  pd_q <= PD_DEFAULT;
    else if (hw_rq || soft_trig) pd_q <= PD_DEFAULT;
    else if (pd_ok)              pd_q <= pd_val;
  end
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rq,
  input  logic       soft_trig,
  input  logic       ord_cmd,
  input  logic       stby_req,
  output logic [1:0] pwr_state,
  output logic       in_reset,
  output logic       regs_rst,
  output logic       filt_clr,
  output logic       conv_abort,
  output logic       host_wr_en
);
  localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

  pstate_t       state_q;
  logic [CW-1:0] cnt_q;
  logic          hard_q;
  logic          abort_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= PS_RESET;
      cnt_q   <= '0;
      hard_q  <= 1'b1;
      abort_q <= 1'b0;
    end else if (hw_rq) begin
      abort_q <= (state_q == PS_ACTIVE);
      state_q <= PS_RESET;
      cnt_q   <= '0;
      hard_q  <= 1'b1;
    end else begin
      abort_q <= 1'b0;
      unique case (state_q)
        PS_RESET: begin
          if (phase_done(int'(cnt_q), RST_CYCLES)) state_q <= PS_STANDBY;
          else                                      cnt_q   <= cnt_q + CW'(1);
        end
        PS_STANDBY: begin
          if (soft_trig) begin
            state_q <= PS_RESET;
            cnt_q   <= '0;
            hard_q  <= 1'b0;
          end else if (ord_cmd) begin
            state_q <= PS_ACTIVE;
          end
        end
        PS_ACTIVE: begin
          if (soft_trig) begin
            state_q <= PS_RESET;
            cnt_q   <= '0;
            hard_q  <= 1'b0;
          end else if (stby_req) begin
            state_q <= PS_STANDBY;
          end
        end
        default: state_q <= PS_RESET;
      endcase
    end
  end

  assign pwr_state  = state_q;
  assign in_reset   = (state_q == PS_RESET);
  assign regs_rst   = in_reset;
  assign filt_clr   = in_reset && hard_q;
  assign conv_abort = abort_q;
  assign host_wr_en = !in_reset;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rst_n,
  input  logic       pd_wr,
  input  logic [1:0] pd_val,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_mode,
  output logic [1:0] pwr_state,
  output logic       in_reset,
  output logic       regs_rst,
  output logic       filt_clr,
  output logic       conv_abort,
  output logic       host_wr_en
);
  logic pin_synced;
  logic hw_rq;
  logic soft_trig;
  logic ord_cmd;
  logic stby_req;

  rsq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .por_n(por_n),
    .din  (hw_rst_n),
    .dout (pin_synced)
  );

  assign hw_rq = !pin_synced;

  rsq_cmd_decode i_dec (
    .clk       (clk),
    .por_n     (por_n),
    .hw_rq     (hw_rq),
    .host_wr_en(host_wr_en),
    .pd_wr     (pd_wr),
    .pd_val    (pd_val),
    .cmd_wr    (cmd_wr),
    .cmd_mode  (cmd_mode),
    .soft_trig (soft_trig),
    .ord_cmd   (ord_cmd),
    .stby_req  (stby_req)
  );

  rsq_fsm #(.RST_CYCLES(RST_CYCLES)) i_fsm (
    .clk       (clk),
    .por_n     (por_n),
    .hw_rq     (hw_rq),
    .soft_trig (soft_trig),
    .ord_cmd   (ord_cmd),
    .stby_req  (stby_req),
    .pwr_state (pwr_state),
    .in_reset  (in_reset),
    .regs_rst  (regs_rst),
    .filt_clr  (filt_clr),
    .conv_abort(conv_abort),
    .host_wr_en(host_wr_en)
  );
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
  input logic       clk,
  input logic       por_n,
  input logic [1:0] pwr_state,
  input logic       in_reset,
  input logic       filt_clr,
  input logic       conv_abort,
  input logic       host_wr_en,
  input logic       hw_rq,
  input logic       soft_trig,
  input logic       ord_cmd
);
  assert_flag_matches_code_R2: assert property (@(posedge clk) disable iff (!por_n)
    in_reset == (pwr_state == 2'b11));

  assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!por_n)
    in_reset |-> (!host_wr_en && !soft_trig && !ord_cmd));

  assert_pin_resets_R4: assert property (@(posedge clk) disable iff (!por_n)
    hw_rq |=> (in_reset && filt_clr));

  assert_abort_single_R5: assert property (@(posedge clk) disable iff (!por_n)
    conv_abort |=> !conv_abort);

  assert_abort_from_active_R5: assert property (@(posedge clk) disable iff (!por_n)
    conv_abort |-> ($past(pwr_state) == 2'b00 && in_reset));

  assert_exit_to_standby_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(in_reset) |-> (pwr_state == 2'b10));

  assert_soft_is_light_R7: assert property (@(posedge clk) disable iff (!por_n)
    (soft_trig && !hw_rq) |=> (in_reset && !filt_clr && !conv_abort));

  assert_ordinary_starts_R9: assert property (@(posedge clk) disable iff (!por_n)
    (ord_cmd && !hw_rq && pwr_state == 2'b10) |=> (pwr_state == 2'b00));
endmodule

bind rst_seq_ctrl rsq_checker i_rsq_checker (
  .clk       (clk),
  .por_n     (por_n),
  .pwr_state (pwr_state),
  .in_reset  (in_reset),
  .filt_clr  (filt_clr),
  .conv_abort(conv_abort),
  .host_wr_en(host_wr_en),
  .hw_rq     (hw_rq),
  .soft_trig (soft_trig),
  .ord_cmd   (ord_cmd)
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;
  localparam int RC = 6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       hw_rst_n = 1'b1;
  logic       pd_wr = 1'b0;
  logic [1:0] pd_val = 2'b00;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic [1:0] pwr_state;
  logic       in_reset, regs_rst, filt_clr, conv_abort, host_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic       ir, we, rr, fc, ca;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rst_seq_ctrl #(.RST_CYCLES(RC)) i_rst_seq_ctrl (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n),
    .pd_wr(pd_wr), .pd_val(pd_val), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
    .pwr_state(pwr_state), .in_reset(in_reset), .regs_rst(regs_rst),
    .filt_clr(filt_clr), .conv_abort(conv_abort), .host_wr_en(host_wr_en)
  );

  // Monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if ({pwr_state, in_reset, host_wr_en, regs_rst, filt_clr, conv_abort} !==
          {e.st, e.ir, e.we, e.rr, e.fc, e.ca}) begin
        errors++;
        $display("FAIL %s: got st=%b ir=%b we=%b rr=%b fc=%b ca=%b, expected st=%b ir=%b we=%b rr=%b fc=%b ca=%b",
                 e.tag, pwr_state, in_reset, host_wr_en, regs_rst, filt_clr, conv_abort,
                 e.st, e.ir, e.we, e.rr, e.fc, e.ca);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input string tag, input logic [1:0] st, input logic ir,
                      input logic we, input logic rr, input logic fc, input logic ca);
    exp_t e;
    e.tag = tag; e.st = st; e.ir = ir; e.we = we; e.rr = rr; e.fc = fc; e.ca = ca;
    q.push_back(e);
  endtask

  task automatic exp_standby(input string tag); push(tag, 2'b10, 0, 1, 0, 0, 0); endtask
  task automatic exp_active(input string tag);  push(tag, 2'b00, 0, 1, 0, 0, 0); endtask
  task automatic exp_hard(input string tag, input logic ca); push(tag, 2'b11, 1, 0, 1, 1, ca); endtask
  task automatic exp_soft(input string tag);    push(tag, 2'b11, 1, 0, 1, 0, 0); endtask

  task automatic send_pd(input logic [1:0] v);
    pd_wr = 1'b1; pd_val = v; step(); pd_wr = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] m);
    cmd_wr = 1'b1; cmd_mode = m; step(); cmd_wr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected end of run");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: held in power-on reset
    step(); step();
    exp_hard("R1 por held", 1'b0);
    por_n = 1'b1;
    for (int i = 1; i <= RC + 1; i++) begin
      step(); exp_hard("R1 R10 por phase", 1'b0);
    end
    step(); exp_standby("R1 R6 standby after por");
    for (int i = 0; i < 3; i++) begin
      step(); exp_standby("R6 standby holds");
    end

    // R9: ordinary command, then back to standby
    send_cmd(2'b01); exp_active("R9 mode 01 unarmed is ordinary");
    send_pd(2'b01);  exp_standby("R9 pd 01 returns to standby");

    // R7: two-step software reset; R3: writes blocked during it
    send_pd(2'b11);  exp_standby("R7 arming keeps standby");
    send_cmd(2'b01); exp_soft("R7 soft reset entered");
    for (int i = 1; i <= RC - 1; i++) begin
      if (i == 1) begin pd_wr = 1'b1; pd_val = 2'b11; end
      if (i == 2) begin cmd_wr = 1'b1; cmd_mode = 2'b01; end
      step();
      pd_wr = 1'b0; cmd_wr = 1'b0;
      exp_soft("R7 R3 soft phase, writes ignored");
    end
    step(); exp_standby("R7 soft reset complete");

    // R8 and R3: field restored and blocked writes left no trace
    send_cmd(2'b01); exp_active("R8 R3 mode 01 after soft reset is ordinary");

    // R4 R5: hardware reset during a conversion
    hw_rst_n = 1'b0;
    step(); exp_active("R4 sync stage 1");
    step(); exp_active("R4 sync stage 2");
    step(); exp_hard("R4 R5 hard reset with abort", 1'b1);
    step(); exp_hard("R5 abort single cycle", 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(); exp_hard("R10 pin held restarts count", 1'b0);
    end
    hw_rst_n = 1'b1;
    for (int i = 1; i <= RC + 1; i++) begin
      step(); exp_hard("R10 phase after pin release", 1'b0);
    end
    step(); exp_standby("R6 standby after pin reset");

    // R11: pin request and completing command on the same edge
    send_pd(2'b11); exp_standby("R11 armed");
    hw_rst_n = 1'b0;
    step(); step();
    send_cmd(2'b01); exp_hard("R11 pin wins, filter cleared", 1'b0);
    hw_rst_n = 1'b1;
    for (int i = 1; i <= RC + 1; i++) begin
      step(); exp_hard("R11 hard phase", 1'b0);
    end
    step(); exp_standby("R11 standby");
    send_cmd(2'b01); exp_active("R11 field cleared, ordinary command");
    send_pd(2'b01);  exp_standby("R9 back to standby");

    @(negedge clk);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule